// File: doc/BRIEF.md
# Per-Region Word Locality Predictor

This block guesses, on a cache miss, which 64-bit words of a 64-byte region are worth fetching. It keeps a table of small bitmaps, one bit per word of a region, that remember which words a block of that region actually used during its last stay in the cache. The table is indexed by a folded hash of either the region address or the program counter together with the missing word's offset; a mode input picks which. Unrelated regions may share an entry, and that sharing is accepted.

On a miss the stored bitmap is turned into one contiguous run of words from its lowest to its highest marked word, widened so that it always contains the missing word. An untrained entry, or one that holds no marked word, asks for the whole region. Words at either end of the run that the cache already holds for the region are then cut away, up to but never past the missing word; cached words inside the run stay in the request. The result comes out one cycle after the miss as a start and end word offset, together with the table index used. The cache keeps that index with the block and, on eviction, hands it back with the block's used-word mask so the history lands in the same entry.

Top module: `word_locality_predictor`

## Requirements
- R1: After reset `pred_valid_o` is 0 and every table entry is untrained, so the first prediction for any index covers words 0 to 7 before trimming.
- R2: With `mode_i`=0 the index is the XOR fold of `miss_region_i`: address bit i is XORed into index bit (i mod 8).
- R3: With `mode_i`=1 the index is the XOR fold of the key {`miss_pc_i`, `miss_word_i`} (word offset in the three low key bits), bit i into index bit (i mod 8).
- R4: `pred_valid_o` is 1 exactly in the cycle after a cycle with `miss_valid_i`=1, and carries the index of that miss on `pred_idx_o`.
- R5: An untrained entry or an entry whose bitmap is all zero predicts the full region, words 0 to 7.
- R6: A trained entry predicts from its lowest set bit to its highest set bit, widened so that `miss_word_i` lies inside the range (bit n of a bitmap stands for word n).
- R7: Starting at the low end, words marked in `miss_cached_i` (bit n = word n) are removed one by one until an uncached word or the missing word is reached.
- R8: Starting at the high end, cached words are removed the same way, stopping at an uncached word or the missing word.
- R9: Cached words strictly between the trimmed start and end remain inside the range.
- R10: `evict_valid_i` stores `evict_used_i` as the bitmap of entry `evict_idx_i` and marks it trained; later misses to that index use it.
- R11: When an eviction and a miss touch the same index in one cycle, that miss is predicted from the entry's previous contents.
- R12: Different regions that fold to the same index share one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Index source: 0 region address, 1 program counter with word offset |
| miss_valid_i | input | 1 | A miss needs a prediction this cycle |
| miss_region_i | input | 24 | Region address of the miss |
| miss_pc_i | input | 32 | Program counter of the missing access |
| miss_word_i | input | 3 | Word offset of the missing access in its region |
| miss_cached_i | input | 8 | Words of the region already present in the cache |
| evict_valid_i | input | 1 | A block is being evicted this cycle |
| evict_idx_i | input | 8 | Table index recorded for the block at fetch time |
| evict_used_i | input | 8 | Words the block used during its stay |
| pred_valid_o | output | 1 | Prediction result valid |
| pred_idx_o | output | 8 | Table index used by the prediction |
| pred_start_o | output | 3 | First word to fetch |
| pred_end_o | output | 3 | Last word to fetch |

## Verification
The bench aims at the trimming edges: runs of cached words at the low end that reach the missing word, which a wrong design would trim past so the missing word falls out of the request, and cached interior words that a greedy design would wrongly split around. It trains an entry and misses in the same cycle on the same index, where a design that forwards the write would return the new bitmap a cycle early. It writes an all-zero mask, which a design that trusts the trained flag alone would turn into an empty or one-word range, and it forces two regions onto one index so a design hashing different bits would fail to share history.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int REGION_WORDS = 8;
  localparam int TABLE_DEPTH  = 256;
  localparam int REGION_AW    = 24;
  localparam int PC_AW        = 32;

  typedef enum logic {
    IDX_BY_REGION = 1'b0,
    IDX_BY_PC     = 1'b1
  } lp_mode_e;
endpackage

// File: rtl/lp_index_fold.sv
module lp_index_fold #(
  parameter int KEY_W = 24,
  parameter int IDX_W = 8
) (
  input  logic [KEY_W-1:0] key_i,
  output logic [IDX_W-1:0] idx_o
);
  // Bit i of the key lands in index bit (i mod IDX_W).
  function automatic logic [IDX_W-1:0] fold_key(input logic [KEY_W-1:0] k);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < KEY_W; i++) begin
      h[i % IDX_W] = h[i % IDX_W] ^ k[i];
    end
    return h;
  endfunction

  assign idx_o = fold_key(key_i);
endmodule

// File: rtl/lp_history_table.sv
module lp_history_table #(
  parameter int WORDS = 8,
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WORDS-1:0] wr_bits_i,
  output logic             rd_trained_o,
  output logic [WORDS-1:0] rd_bits_o
);
  logic [WORDS-1:0] hist_mem [DEPTH];
  logic [DEPTH-1:0] trained_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trained_q <= '0;
    end else if (wr_en_i) begin
      trained_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      hist_mem[wr_idx_i] <= wr_bits_i;
    end
  end

  // Read sees the contents before any write of the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_trained_o <= 1'b0;
      rd_bits_o    <= '0;
    end else if (rd_en_i) begin
      rd_trained_o <= trained_q[rd_idx_i];
      rd_bits_o    <= hist_mem[rd_idx_i];
    end
  end

  AST_WRITE_TRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> trained_q[$past(wr_idx_i)]); // R10
endmodule

// File: rtl/lp_range_former.sv
module lp_range_former #(
  parameter int WORDS = 8,
  localparam int WI_W = $clog2(WORDS)
) (
  input  logic             trained_i,
  input  logic [WORDS-1:0] bits_i,
  input  logic [WI_W-1:0]  miss_word_i,
  input  logic [WORDS-1:0] cached_i,
  output logic [WI_W-1:0]  start_o,
  output logic [WI_W-1:0]  end_o
);
  function automatic logic [WI_W-1:0] lowest_set(input logic [WORDS-1:0] v);
    logic [WI_W-1:0] r;
    r = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (v[i]) r = WI_W'(i);
    end
    return r;
  endfunction

  function automatic logic [WI_W-1:0] highest_set(input logic [WORDS-1:0] v);
    logic [WI_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (v[i]) r = WI_W'(i);
    end
    return r;
  endfunction

  function automatic logic [WI_W-1:0] trim_low(input logic [WI_W-1:0] s,
                                               input logic [WI_W-1:0] m,
                                               input logic [WORDS-1:0] c);
    logic [WI_W-1:0] r;
    logic go;
    r  = s;
    go = 1'b1;
    for (int i = 0; i < WORDS; i++) begin
      if (go && i >= int'(s) && i < int'(m)) begin
        if (c[i]) r = WI_W'(i + 1);
        else      go = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic logic [WI_W-1:0] trim_high(input logic [WI_W-1:0] e,
                                                input logic [WI_W-1:0] m,
                                                input logic [WORDS-1:0] c);
    logic [WI_W-1:0] r;
    logic go;
    r  = e;
    go = 1'b1;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (go && i <= int'(e) && i > int'(m)) begin
        if (c[i]) r = WI_W'(i - 1);
        else      go = 1'b0;
      end
    end
    return r;
  endfunction

  logic [WORDS-1:0] pattern;
  logic [WI_W-1:0]  lo_bit, hi_bit, raw_start, raw_end;

  always_comb begin
    pattern   = (trained_i && (|bits_i)) ? bits_i : '1;
    lo_bit    = lowest_set(pattern);
    hi_bit    = highest_set(pattern);
    raw_start = (lo_bit < miss_word_i) ? lo_bit : miss_word_i;
    raw_end   = (hi_bit > miss_word_i) ? hi_bit : miss_word_i;
    start_o   = trim_low(raw_start, miss_word_i, cached_i);
    end_o     = trim_high(raw_end, miss_word_i, cached_i);
  end
endmodule

// File: rtl/word_locality_predictor.sv
module word_locality_predictor #(
  parameter int WORDS    = lp_pkg::REGION_WORDS,
  parameter int DEPTH    = lp_pkg::TABLE_DEPTH,
  parameter int REGION_W = lp_pkg::REGION_AW,
  parameter int PC_W     = lp_pkg::PC_AW,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int WI_W    = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_i,
  input  logic                miss_valid_i,
  input  logic [REGION_W-1:0] miss_region_i,
  input  logic [PC_W-1:0]     miss_pc_i,
  input  logic [WI_W-1:0]     miss_word_i,
  input  logic [WORDS-1:0]    miss_cached_i,
  input  logic                evict_valid_i,
  input  logic [IDX_W-1:0]    evict_idx_i,
  input  logic [WORDS-1:0]    evict_used_i,
  output logic                pred_valid_o,
  output logic [IDX_W-1:0]    pred_idx_o,
  output logic [WI_W-1:0]     pred_start_o,
  output logic [WI_W-1:0]     pred_end_o
);
  import lp_pkg::*;

  lp_mode_e         mode_sel;
  logic [IDX_W-1:0] idx_region, idx_pc, idx_sel;
  logic             miss_fire, evict_fire;
  logic             pend_q;
  logic [IDX_W-1:0] idx_q;
  logic [WI_W-1:0]  word_q;
  logic [WORDS-1:0] cached_q;
  logic             tab_trained;
  logic [WORDS-1:0] tab_bits;

  assign mode_sel   = lp_mode_e'(mode_i);
  assign miss_fire  = miss_valid_i;
  assign evict_fire = evict_valid_i;

  lp_index_fold #(.KEY_W(REGION_W), .IDX_W(IDX_W)) u_fold_region (
    .key_i (miss_region_i),
    .idx_o (idx_region)
  );

  lp_index_fold #(.KEY_W(PC_W + WI_W), .IDX_W(IDX_W)) u_fold_pc (
    .key_i ({miss_pc_i, miss_word_i}),
    .idx_o (idx_pc)
  );

  assign idx_sel = (mode_sel == IDX_BY_PC) ? idx_pc : idx_region;

  lp_history_table #(.WORDS(WORDS), .DEPTH(DEPTH)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en_i      (miss_fire),
    .rd_idx_i     (idx_sel),
    .wr_en_i      (evict_fire),
    .wr_idx_i     (evict_idx_i),
    .wr_bits_i    (evict_used_i),
    .rd_trained_o (tab_trained),
    .rd_bits_o    (tab_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      idx_q    <= '0;
      word_q   <= '0;
      cached_q <= '0;
    end else begin
      pend_q <= miss_fire;
      if (miss_fire) begin
        idx_q    <= idx_sel;
        word_q   <= miss_word_i;
        cached_q <= miss_cached_i;
      end
    end
  end

  lp_range_former #(.WORDS(WORDS)) u_range (
    .trained_i   (tab_trained),
    .bits_i      (tab_bits),
    .miss_word_i (word_q),
    .cached_i    (cached_q),
    .start_o     (pred_start_o),
    .end_o       (pred_end_o)
  );

  assign pred_valid_o = pend_q;
  assign pred_idx_o   = idx_q;

  AST_PRED_FOLLOWS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid_i |=> pred_valid_o); // R4
  AST_NO_SPURIOUS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid_i |=> !pred_valid_o); // R4
  AST_MISS_WORD_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid_o |-> (pred_start_o <= word_q) && (word_q <= pred_end_o)); // R6
  AST_START_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid_o && pred_start_o != word_q) |-> !cached_q[pred_start_o]); // R7
  AST_END_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid_o && pred_end_o != word_q) |-> !cached_q[pred_end_o]); // R8
endmodule

// File: tb/word_locality_predictor_bench.sv
module word_locality_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_i = 1'b0;
  logic        miss_valid_i = 1'b0;
  logic [23:0] miss_region_i = '0;
  logic [31:0] miss_pc_i = '0;
  logic [2:0]  miss_word_i = '0;
  logic [7:0]  miss_cached_i = '0;
  logic        evict_valid_i = 1'b0;
  logic [7:0]  evict_idx_i = '0;
  logic [7:0]  evict_used_i = '0;
  logic        pred_valid_o;
  logic [7:0]  pred_idx_o;
  logic [2:0]  pred_start_o, pred_end_o;

  int checks = 0;
  int errors = 0;
  int model [int];
  bit exp_v;
  int exp_idx, exp_s, exp_e;

  always #2 clk = ~clk;

  word_locality_predictor u_word_locality_predictor (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .miss_valid_i(miss_valid_i),
    .miss_region_i(miss_region_i), .miss_pc_i(miss_pc_i), .miss_word_i(miss_word_i),
    .miss_cached_i(miss_cached_i), .evict_valid_i(evict_valid_i),
    .evict_idx_i(evict_idx_i), .evict_used_i(evict_used_i),
    .pred_valid_o(pred_valid_o), .pred_idx_o(pred_idx_o),
    .pred_start_o(pred_start_o), .pred_end_o(pred_end_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Byte-wise XOR fold, a different shape from the design's bit-wise loop.
  function automatic int fold8(longint unsigned key, int width);
    int h = 0;
    for (int c = 0; c < width; c += 8) h ^= int'((key >> c) & 64'hFF);
    return h;
  endfunction

  task automatic step();
    bit nv = 0;
    int ni = 0, ns = 0, ne = 0;
    if (miss_valid_i) begin
      int pat, m, lo, hi;
      nv = 1;
      m  = int'(miss_word_i);
      if (mode_i) ni = fold8({29'd0, miss_pc_i, miss_word_i}, 35);
      else        ni = fold8({40'd0, miss_region_i}, 24);
      pat = model.exists(ni) ? model[ni] : 0;
      if (pat == 0) pat = 8'hFF;
      lo = 0; while (((pat >> lo) & 1) == 0) lo++;
      hi = 7; while (((pat >> hi) & 1) == 0) hi--;
      if (m < lo) lo = m;
      if (m > hi) hi = m;
      while (lo < m && miss_cached_i[lo]) lo++;
      while (hi > m && miss_cached_i[hi]) hi--;
      ns = lo; ne = hi;
    end
    if (evict_valid_i) model[int'(evict_idx_i)] = int'(evict_used_i);
    @(posedge clk);
    @(negedge clk);
    exp_v = nv; exp_idx = ni; exp_s = ns; exp_e = ne;
    check("R4 valid", int'(pred_valid_o), int'(exp_v));
    if (exp_v && pred_valid_o) begin
      check(mode_i ? "R3 index" : "R2 index", int'(pred_idx_o), exp_idx);
      check("R6 start", int'(pred_start_o), exp_s);
      check("R6 end", int'(pred_end_o), exp_e);
    end
    miss_valid_i  = 1'b0;
    evict_valid_i = 1'b0;
  endtask

  task automatic miss(bit md, logic [23:0] reg_a, logic [31:0] pc, int w, logic [7:0] c);
    mode_i = md; miss_valid_i = 1'b1; miss_region_i = reg_a;
    miss_pc_i = pc; miss_word_i = 3'(w); miss_cached_i = c;
  endtask

  task automatic evict(int idx, logic [7:0] used);
    evict_valid_i = 1'b1; evict_idx_i = 8'(idx); evict_used_i = used;
  endtask

  task automatic expect_range(string req, int s, int e);
    check(req, int'(pred_start_o), s);
    check(req, int'(pred_end_o), e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(pred_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(pred_valid_o), 0);

    // R1 R2 R5: untrained region index 0x12^0x34^0x56 = 0x70
    miss(0, 24'h123456, 0, 3, 8'h00); step();
    check("R2 fold", int'(pred_idx_o), 8'h70);
    expect_range("R1 R5 untrained full", 0, 7);

    // R10 R6: train words 2 and 5
    evict(8'h70, 8'b0010_0100); step();
    miss(0, 24'h123456, 0, 3, 8'h00); step(); expect_range("R10 R6 span", 2, 5);
    miss(0, 24'h123456, 0, 7, 8'h00); step(); expect_range("R6 widen high", 2, 7);
    miss(0, 24'h123456, 0, 0, 8'h00); step(); expect_range("R6 widen low", 0, 5);

    // R7 R8 R9 trimming
    miss(0, 24'h123456, 0, 4, 8'b0000_1100); step(); expect_range("R7 start trim", 4, 5);
    miss(0, 24'h123456, 0, 2, 8'b0011_0000); step(); expect_range("R8 end trim", 2, 3);
    miss(0, 24'h123456, 0, 2, 8'b0000_1000); step(); expect_range("R9 interior kept", 2, 5);
    miss(0, 24'h123456, 0, 3, 8'b0011_0111); step(); expect_range("R7 R8 stop at miss", 3, 3);

    // R3: key {0x1000, 3'd1} = 0x8001 -> 0x81
    miss(1, 24'h0, 32'h0000_1000, 1, 8'h00); step();
    check("R3 fold", int'(pred_idx_o), 8'h81);
    expect_range("R3 R5 untrained full", 0, 7);

    // R5 R10: zero mask trains entry to predict full region
    evict(8'h70, 8'h00); step();
    miss(0, 24'h123456, 0, 4, 8'h00); step(); expect_range("R5 zero entry", 0, 7);

    // R11: same-cycle write and read use old contents
    evict(8'h70, 8'b1000_0000); miss(0, 24'h123456, 0, 6, 8'h00); step();
    expect_range("R11 old contents", 0, 7);
    miss(0, 24'h123456, 0, 6, 8'h00); step(); expect_range("R11 new contents", 6, 7);

    // R12: region 0x000070 aliases onto index 0x70
    miss(0, 24'h000070, 0, 6, 8'h00); step();
    check("R12 alias index", int'(pred_idx_o), 8'h70);
    expect_range("R12 shared entry", 6, 7);

    // Mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) != 0)
        miss(1'($urandom_range(0, 1)), 24'($urandom_range(0, 7)),
             32'($urandom_range(0, 3)), int'($urandom_range(0, 7)), 8'($urandom));
      if ($urandom_range(0, 2) == 0)
        evict(int'($urandom_range(0, 7)), 8'($urandom));
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule